// File: doc/BRIEF.md
# Interrupt State Tracking Controller

This block collects raw request lines from up to a few hundred device sources and keeps two state bits for each interrupt ID: pending and active. Together these give four states: inactive, pending, active, and active+pending. Every source has an enable bit, a trigger-mode bit that selects level or edge behaviour, and a routing byte that picks the cores it may interrupt. Each core gets one IRQ line. That line is high while at least one interrupt is enabled, pending, not active and routed to that core.

Software runs the lifecycle through a simple word-addressed register port. A read of the acknowledge address returns the lowest-numbered eligible ID for the requesting core and marks that interrupt active. A write of an ID to the end-of-interrupt address clears that interrupt's active bit. Level sources keep their pending bit equal to the synchronized line. Edge sources latch a rising edge and hold it until an acknowledge.

Addresses are byte addresses on 32-bit words. Enable words start at 0x000, mode words at 0x080, routing words at 0x100, pending status words at 0x200, active status words at 0x280. The acknowledge register is at 0x300 and the end-of-interrupt register is at 0x304. Unmapped reads return zero. NUM_IRQ may be at most 256.

Top module: `irq_state_ctrl`

## Requirements
- R1: After reset every enable, mode, pending and active bit is 0 (0 means level mode), every routing byte is 0x01 (core 0 only), and every irq_o bit is 0.
- R2: Interrupt n has its enable at word 0x000+4*(n/32), bit n%32, and its mode at word 0x080+4*(n/32), bit n%32, where 1 means edge. Its routing byte sits at word 0x100+4*(n/4), bits 8*(n%4) and up, and bit c of that byte selects core c. Bits for cores at or above NUM_CORES read back as 0.
- R3: For a level-mode source, the pending bit (word 0x200+4*(n/32), bit n%32) follows the input line with a 3-cycle latency in both directions.
- R4: For an edge-mode source, a 0-to-1 transition of the synchronized line sets pending 3 cycles later. Pending stays set after the line falls, until an acknowledge selects that interrupt.
- R5: irq_o[c] is 1 exactly when some interrupt is enabled, pending, not active and has routing bit c set. It falls in the cycle right after the acknowledge that removes the last such interrupt.
- R6: A read of 0x300 with reg_core_i = c returns, on the next cycle, the lowest eligible ID for core c in bits [ID_W-1:0]. All higher bits are 0.
- R7: Acknowledging an edge-mode interrupt clears its pending bit and sets its active bit (word 0x280+4*(n/32), bit n%32).
- R8: Acknowledging a level-mode interrupt whose line is still high leaves it both active and pending.
- R9: Writing ID n to 0x304 clears active for n. If n is still pending and enabled, its IRQ line rises again.
- R10: With no eligible interrupt for the requesting core, an acknowledge read returns all ones in the ID field (1023 for ID_W = 10) and changes no state.
- R11: A new rising edge on an edge-mode source that is already active sets pending again, so the interrupt becomes active+pending.
- R12: A disabled interrupt still tracks pending, but it drives no IRQ line and is never picked by an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_IRQ | Raw device request lines, asynchronous |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address of the word accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_core_i | input | CORE_W | Core issuing the access, used by the acknowledge read |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | NUM_CORES | Per-core interrupt request |

## Verification
A change on a source line reaches the pending bit and irq_o on the third rising edge. The bench changes lines at a falling edge, then samples irq_o at the falling edges just before and just after that third edge to pin the latency. Read data, including the acknowledge result, appears one cycle after the strobe, so every read task raises the strobe at a falling edge and samples at the next one. The drop of irq_o after an acknowledge and its return after an end-of-interrupt write are both sampled at the falling edge right after the access, which is the first point at which the new state can be seen.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] ENA_BASE  = 12'h000;
  localparam logic [ADDR_W-1:0] MODE_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] TGT_BASE  = 12'h100;
  localparam logic [ADDR_W-1:0] PEND_BASE = 12'h200;
  localparam logic [ADDR_W-1:0] ACT_BASE  = 12'h280;
  localparam logic [ADDR_W-1:0] ACK_ADDR  = 12'h300;
  localparam logic [ADDR_W-1:0] EOI_ADDR  = 12'h304;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0] rise_i,
  input  logic [NUM_IRQ-1:0] edge_mode_i,
  input  logic [NUM_IRQ-1:0] ack_i,
  input  logic [NUM_IRQ-1:0] eoi_i,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic pend_q, act_q, pend_d, act_d;

    // level: mirror the line; edge: latch rise, drop on ack (a new rise wins)
    assign pend_d = edge_mode_i[i] ? ((pend_q & ~ack_i[i]) | rise_i[i]) : lvl_i[i];
    assign act_d  = (act_q & ~eoi_i[i]) | ack_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        pend_q <= pend_d;
        act_q  <= act_d;
      end
    end

    assign pending_o[i] = pend_q;
    assign active_o[i]  = act_q;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N    = 8,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]    req_i,
  output logic            vld_o,
  output logic [ID_W-1:0] id_o,
  output logic [N-1:0]    onehot_o
);
  always_comb begin
    logic found;
    found    = 1'b0;
    id_o     = '0;
    onehot_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        id_o        = ID_W'(i);
        onehot_o[i] = 1'b1;
      end
      found = found | req_i[i];
    end
    vld_o = found;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_state_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int NUM_CORES = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [NUM_IRQ-1:0]                 pending_i,
  input  logic [NUM_IRQ-1:0]                 active_i,
  output logic [NUM_IRQ-1:0]                 enable_o,
  output logic [NUM_IRQ-1:0]                 edge_mode_o,
  output logic [NUM_IRQ-1:0][NUM_CORES-1:0]  target_o,
  output logic [DATA_W-1:0]                  rdata_o
);
  localparam logic [NUM_CORES-1:0] TGT_RST = NUM_CORES'(1);

  logic [NUM_IRQ-1:0]                ena_q, mode_q;
  logic [NUM_IRQ-1:0][NUM_CORES-1:0] tgt_q;
  logic                              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q  <= '0;
      mode_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) tgt_q[i] <= TGT_RST;
    end else if (we_i) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (addr_i == ENA_BASE + ADDR_W'(4 * (i / 32)))  ena_q[i]  <= wdata_i[i % 32];
        if (addr_i == MODE_BASE + ADDR_W'(4 * (i / 32))) mode_q[i] <= wdata_i[i % 32];
        if (addr_i == TGT_BASE + ADDR_W'(4 * (i / 4)))
          tgt_q[i] <= wdata_i[8 * (i % 4) +: NUM_CORES];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (addr_i == ENA_BASE + ADDR_W'(4 * (i / 32)))  rdata_o[i % 32] = ena_q[i];
      if (addr_i == MODE_BASE + ADDR_W'(4 * (i / 32))) rdata_o[i % 32] = mode_q[i];
      if (addr_i == PEND_BASE + ADDR_W'(4 * (i / 32))) rdata_o[i % 32] = pending_i[i];
      if (addr_i == ACT_BASE + ADDR_W'(4 * (i / 32)))  rdata_o[i % 32] = active_i[i];
      if (addr_i == TGT_BASE + ADDR_W'(4 * (i / 4)))
        rdata_o[8 * (i % 4) +: NUM_CORES] = tgt_q[i];
    end
  end

  assign enable_o    = ena_q;
  assign edge_mode_o = mode_q;
  assign target_o    = tgt_q;
endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl
  import irq_state_pkg::*;
#(
  parameter int NUM_IRQ   = 128,
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 10,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   src_i,
  input  logic                 reg_re_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  input  logic [CORE_W-1:0]    reg_core_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

  logic [NUM_IRQ-1:0]                  lvl, rise, enable, edge_mode;
  logic [NUM_IRQ-1:0]                  pending, active;
  logic [NUM_IRQ-1:0][NUM_CORES-1:0]   target;
  logic [NUM_CORES-1:0][NUM_IRQ-1:0]   elig;
  logic [NUM_IRQ-1:0]                  ack_req, pick_onehot, ack_onehot, eoi_onehot;
  logic                                pick_vld, ack_fire, eoi_fire;
  logic [ID_W-1:0]                     pick_id;
  logic [DATA_W-1:0]                   cfg_rdata, rdata_q;

  irq_sync_bank #(.WIDTH(NUM_IRQ)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  irq_cfg_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pending_i  (pending),
    .active_i   (active),
    .enable_o   (enable),
    .edge_mode_o(edge_mode),
    .target_o   (target),
    .rdata_o    (cfg_rdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
      assign elig[c][i] = enable[i] & pending[i] & ~active[i] & target[i][c];
    end
    assign irq_o[c] = |elig[c];
  end

  assign ack_req = elig[reg_core_i];

  irq_lowest_pick #(.N(NUM_IRQ), .ID_W(ID_W)) i_pick (
    .req_i   (ack_req),
    .vld_o   (pick_vld),
    .id_o    (pick_id),
    .onehot_o(pick_onehot)
  );

  assign ack_fire   = reg_re_i & (reg_addr_i == ACK_ADDR);
  assign eoi_fire   = reg_we_i & (reg_addr_i == EOI_ADDR);
  assign ack_onehot = ack_fire ? pick_onehot : '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_eoi
    assign eoi_onehot[i] = eoi_fire & (reg_wdata_i[ID_W-1:0] == ID_W'(i));
  end

  irq_state_bank #(.NUM_IRQ(NUM_IRQ)) i_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .rise_i     (rise),
    .edge_mode_i(edge_mode),
    .ack_i      (ack_onehot),
    .eoi_i      (eoi_onehot),
    .pending_o  (pending),
    .active_o   (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (reg_re_i) begin
      if (ack_fire) rdata_q <= DATA_W'(pick_vld ? pick_id : SPURIOUS_ID);
      else          rdata_q <= cfg_rdata;
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irq_state_ctrl_chk.sv
module irq_state_ctrl_chk
  import irq_state_pkg::*;
#(
  parameter int NUM_IRQ   = 128,
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 10,
  parameter int CORE_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_re_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [CORE_W-1:0]    reg_core_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic [NUM_CORES-1:0] irq_o,
  input logic [NUM_IRQ-1:0]   lvl_i,
  input logic [NUM_IRQ-1:0]   edge_mode_i,
  input logic [NUM_IRQ-1:0]   pending_i,
  input logic [NUM_IRQ-1:0]   active_i,
  input logic [NUM_IRQ-1:0]   ack_onehot_i,
  input logic [NUM_IRQ-1:0]   eoi_onehot_i,
  input logic                 pick_vld_i
);
  logic ack_rd;
  assign ack_rd = reg_re_i && (reg_addr_i == ACK_ADDR);

  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pending_i ^ $past(lvl_i)) & ~$past(edge_mode_i) & ~edge_mode_i) == '0);

  p_edge_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pending_i & edge_mode_i & ~ack_onehot_i) & edge_mode_i & ~pending_i) == '0);

  p_irq_ackable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && irq_o[reg_core_i]) |-> pick_vld_i);

  p_ack_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd |=> (reg_rdata_o[DATA_W-1:ID_W] == '0));

  p_ack_sets_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_onehot_i != '0) |=> ((active_i & $past(ack_onehot_i)) == $past(ack_onehot_i)));

  p_eoi_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eoi_onehot_i != '0) && !ack_rd) |=> ((active_i & $past(eoi_onehot_i)) == '0));

  p_spurious_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !pick_vld_i && (eoi_onehot_i == '0)) |=> $stable(active_i));

  p_spurious_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !pick_vld_i) |=> (reg_rdata_o[ID_W-1:0] == '1));
endmodule

bind irq_state_ctrl irq_state_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES), .ID_W(ID_W), .CORE_W(CORE_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_core_i  (reg_core_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .lvl_i       (lvl),
  .edge_mode_i (edge_mode),
  .pending_i   (pending),
  .active_i    (active),
  .ack_onehot_i(ack_onehot),
  .eoi_onehot_i(eoi_onehot),
  .pick_vld_i  (pick_vld)
);

// File: tb/test_irq_state_ctrl.sv
module test_irq_state_ctrl;
  import irq_state_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NI   = 128;
  localparam int NC   = 4;
  localparam int IDW  = 10;
  localparam int SPUR = 1023;

  // stimulus table: id, edge mode, line dropped before acknowledge
  localparam int unsigned V_ID   [6] = '{5, 37, 99, 64, 127, 0};
  localparam bit          V_EDGE [6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam bit          V_DROP [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NI-1:0]     src = '0;
  logic              re = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [1:0]        core = '0;
  logic [DATA_W-1:0] rdata;
  logic [NC-1:0]     irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_state_ctrl #(.NUM_IRQ(NI), .NUM_CORES(NC), .ID_W(IDW)) i_irq_state_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_re_i(re), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_core_i(core),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bit_of(logic [ADDR_W-1:0] base, int n, output logic b);
    logic [31:0] d;
    rd(base + ADDR_W'(4 * (n / 32)), d);
    b = d[n % 32];
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic b;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(ENA_BASE, d);        chk("R1 enable", d, 0);
    rd(MODE_BASE + 12, d);  chk("R1 mode", d, 0);
    rd(TGT_BASE + 40, d);   chk("R1 target", d, 32'h01010101);
    rd(PEND_BASE + 8, d);   chk("R1 pending", d, 0);
    rd(ACT_BASE, d);        chk("R1 active", d, 0);

    // R2 register layout
    wr(ENA_BASE + 4, 32'hA5A50001); rd(ENA_BASE + 4, d); chk("R2 enable rw", d, 32'hA5A50001);
    rd(ENA_BASE, d); chk("R2 enable neighbour", d, 0);
    wr(MODE_BASE + 12, 32'h80000003); rd(MODE_BASE + 12, d); chk("R2 mode rw", d, 32'h80000003);
    wr(TGT_BASE + 40, 32'hFFFFFFFF); rd(TGT_BASE + 40, d); chk("R2 target mask", d, 32'h0F0F0F0F);
    wr(TGT_BASE + 40, 32'h0C0D0E02); rd(TGT_BASE + 40, d); chk("R2 target rw", d, 32'h0C0D0E02);
    wr(ENA_BASE + 4, 0); wr(MODE_BASE + 12, 0); wr(TGT_BASE + 40, 32'h01010101);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 6; v++) begin
      int  id;
      bit  ed, dr, valid;
      id = int'(V_ID[v]); ed = V_EDGE[v]; dr = V_DROP[v];
      valid = ed || !dr;
      wr(ENA_BASE + ADDR_W'(4 * (id / 32)), 32'(1) << (id % 32));
      wr(MODE_BASE + ADDR_W'(4 * (id / 32)), 32'(ed) << (id % 32));
      src[id] = 1'b1;
      wait_n(2); chk("R3 latency before", 32'(irq[0]), 0);
      wait_n(1); chk("R3 latency after", 32'(irq[0]), 1);
      if (dr) begin src[id] = 1'b0; wait_n(4); end
      chk("R4 R5 irq before ack", 32'(irq[0]), 32'(valid));
      rd(ACK_ADDR, d);
      chk("R6 ack id", d, valid ? 32'(id) : 32'(SPUR));
      chk("R5 irq after ack", 32'(irq[0]), 0);
      bit_of(PEND_BASE, id, b); chk(ed ? "R7 pending" : "R8 pending", 32'(b), 32'(!ed && !dr));
      bit_of(ACT_BASE, id, b);  chk(ed ? "R7 active" : "R8 active", 32'(b), 32'(valid));
      if (valid) begin
        wr(EOI_ADDR, 32'(id));
        chk("R9 irq after eoi", 32'(irq[0]), 32'(!ed && !dr));
        bit_of(ACT_BASE, id, b); chk("R9 active cleared", 32'(b), 0);
      end
      src[id] = 1'b0; wait_n(4);
      chk("R3 line low", 32'(irq[0]), 0);
      wr(ENA_BASE + ADDR_W'(4 * (id / 32)), 0);
      wr(MODE_BASE + ADDR_W'(4 * (id / 32)), 0);
    end

    // R11 second edge while active
    wr(ENA_BASE + 4, 32'(1) << 5); wr(MODE_BASE + 4, 32'(1) << 5);
    src[37] = 1'b1; wait_n(4); src[37] = 1'b0; wait_n(2);
    rd(ACK_ADDR, d); chk("R11 first ack", d, 37);
    src[37] = 1'b1; wait_n(4); src[37] = 1'b0;
    bit_of(PEND_BASE, 37, b); chk("R11 pending again", 32'(b), 1);
    bit_of(ACT_BASE, 37, b);  chk("R11 still active", 32'(b), 1);
    chk("R11 irq held off", 32'(irq[0]), 0);
    wr(EOI_ADDR, 37); chk("R11 irq after eoi", 32'(irq[0]), 1);
    rd(ACK_ADDR, d); chk("R11 second ack", d, 37);
    wr(EOI_ADDR, 37);
    wr(ENA_BASE + 4, 0); wr(MODE_BASE + 4, 0);

    // R6 lowest first, R5 routing: 40 to core 1 only
    wr(ENA_BASE, 32'(1) << 9); wr(ENA_BASE + 4, 32'(1) << 8); wr(ENA_BASE + 8, 32'(1) << 6);
    wr(TGT_BASE + 40, 32'h01010102);
    src[70] = 1'b1; src[9] = 1'b1; src[40] = 1'b1; wait_n(4);
    chk("R5 routing irq", 32'(irq), 32'h3);
    rd(ACK_ADDR, d); chk("R6 lowest core0", d, 9);
    rd(ACK_ADDR, d); chk("R6 next core0", d, 70);
    chk("R5 core0 drained", 32'(irq), 32'h2);
    rd(ACK_ADDR, d); chk("R10 spurious core0", d, SPUR);
    core = 2'd1;
    rd(ACK_ADDR, d); chk("R6 core1", d, 40);
    chk("R5 all drained", 32'(irq), 0);
    core = 2'd0;

    // R10 no state change
    rd(ACT_BASE + 4, d); chk("R10 active before", d, 32'(1) << 8);
    rd(ACK_ADDR, d); chk("R10 spurious id", d, SPUR);
    rd(ACT_BASE + 4, d); chk("R10 active after", d, 32'(1) << 8);
    rd(PEND_BASE + 8, d); chk("R10 pending after", d, 32'(1) << 6);
    wr(EOI_ADDR, 9); wr(EOI_ADDR, 70); wr(EOI_ADDR, 40);
    src[70] = 1'b0; src[9] = 1'b0; src[40] = 1'b0; wait_n(4);
    wr(ENA_BASE, 0); wr(ENA_BASE + 4, 0); wr(ENA_BASE + 8, 0);
    wr(TGT_BASE + 40, 32'h01010101);

    // R12 disabled source
    src[20] = 1'b1; wait_n(4);
    bit_of(PEND_BASE, 20, b); chk("R12 pending tracked", 32'(b), 1);
    chk("R12 no irq", 32'(irq), 0);
    rd(ACK_ADDR, d); chk("R12 not picked", d, SPUR);
    bit_of(ACT_BASE, 20, b); chk("R12 not active", 32'(b), 0);
    wr(ENA_BASE, 32'(1) << 20);
    chk("R12 irq once enabled", 32'(irq[0]), 1);
    src[20] = 1'b0; wait_n(4);
    chk("R12 irq after drop", 32'(irq[0]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule